// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block gives each CPU of a cluster two inter-processor interrupts, a cross-CPU kind ("other") and a loop-back kind ("self"). Software drives them through a small set of memory-mapped registers on a shared register bus. Every access on that bus carries the index of the CPU that makes it, so one register address acts on the state of whichever CPU is accessing it. Each CPU owns two bits of state per kind: a pending bit and a mask bit.

A pending, unmasked interrupt becomes an event candidate for its CPU. The block merges that candidate with the CPU's hardware interrupt line into a single per-CPU event register. Reading the event register delivers the reported interrupt. Delivery masks the interrupt on its own, but it does not clear it: clearing is done through the acknowledge register, and re-enabling is done through mask-clear. The block also exposes the event candidate of every CPU as an output, so a wider interrupt fabric can observe it.

Top module: `ipi_unit`

## Requirements
- R1: After reset, both kinds on every CPU are masked and neither is pending. Clearing all masks straight after reset therefore raises no event candidate, and `bus_rvalid` is low.
- R2: A write to the send register (offset 0x2008) sets the "other" pending bit on CPU n for every set bit n in 0..NUM_CPU-1. This holds whichever CPU writes.
- R3: A send write with bit 31 set also sets the "self" pending bit of the writing CPU, and of no other CPU.
- R4: An event word has bits 31:24 zero, a type code in bits 23:16 and a number in bits 15:0. For these interrupts the type code is 4, the number is 1 for "other" and 2 for "self", and `cand_word` carries the same encoding.
- R5: A write to the acknowledge register (0x200C) clears the writer's "other" pending bit where bit 0 is set and its "self" pending bit where bit 31 is set. Other CPUs are not affected.
- R6: A write to mask-set (0x2024) or mask-clear (0x2028) sets or clears the writer's mask bits. Bit 0 selects "other" and bit 31 selects "self"; no other bit selects anything.
- R7: A read of the event register (0x2004) that reports an interrupt sets that interrupt's mask bit and leaves its pending bit set. A later mask-clear shows it again.
- R8: When both kinds are pending and unmasked on one CPU, "other" is reported first.
- R9: When a CPU's hardware line is asserted, its event read returns type code 1 with the hardware number in bits 15:0. In that case no inter-processor interrupt is masked.
- R10: A read of the who-am-I register (0x2000) returns the index of the accessing CPU.
- R11: Read data is registered: `bus_rvalid` is high exactly in the cycle after a read request. An event read with nothing to report returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_cpu | input | CPU_W | Index of the accessing CPU |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| hw_valid | input | NUM_CPU | Per-CPU hardware interrupt present |
| hw_num | input | NUM_CPU*16 | Per-CPU hardware interrupt number |
| cand_valid | output | NUM_CPU | Per-CPU inter-processor event candidate present |
| cand_word | output | NUM_CPU*32 | Per-CPU event word of the candidate |

## Verification
The send register is swept over every target pattern of a four-CPU configuration. Each pattern is written by a different CPU, so the sweep separates target decoding from writer identity. Targeted sequences on a single CPU then put both kinds in flight together, which separates report order, auto-mask on delivery, and the fact that the pending bit survives delivery. Acknowledge and mask writes are issued by a neighbouring CPU and then by the owning CPU, with bit 0 and bit 31 applied separately; this shows that the writer index, and not the address alone, selects the state. An asserted hardware line distinguishes the priority of the merge from an unintended IPI mask side effect.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int NUM_W = 16;

  localparam logic [15:0] OFF_WHOAMI = 16'h2000;
  localparam logic [15:0] OFF_EVENT  = 16'h2004;
  localparam logic [15:0] OFF_SEND   = 16'h2008;
  localparam logic [15:0] OFF_ACK    = 16'h200C;
  localparam logic [15:0] OFF_MSET   = 16'h2024;
  localparam logic [15:0] OFF_MCLR   = 16'h2028;

  localparam logic [7:0] TYPE_HW  = 8'd1;
  localparam logic [7:0] TYPE_IPI = 8'd4;
  localparam logic [NUM_W-1:0] NUM_OTHER = 16'd1;
  localparam logic [NUM_W-1:0] NUM_SELF  = 16'd2;

  localparam int SEL_OTHER = 0;
  localparam int SEL_SELF  = 31;

  typedef enum logic [2:0] {
    OP_NONE, OP_WHOAMI, OP_EVENT, OP_SEND, OP_ACK, OP_MSET, OP_MCLR
  } op_e;

  function automatic logic [31:0] evt_word(input logic [7:0] t, input logic [NUM_W-1:0] n);
    return {8'h00, t, n};
  endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
(
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [15:0] bus_addr,
  output op_e         op
);
  always_comb begin
    op = OP_NONE;
    if (bus_valid) begin
      if (bus_write) begin
        unique case (bus_addr)
          OFF_SEND: op = OP_SEND;
          OFF_ACK:  op = OP_ACK;
          OFF_MSET: op = OP_MSET;
          OFF_MCLR: op = OP_MCLR;
          default:  op = OP_NONE;
        endcase
      end else begin
        unique case (bus_addr)
          OFF_WHOAMI: op = OP_WHOAMI;
          OFF_EVENT:  op = OP_EVENT;
          default:    op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
  import ipi_pkg::*;
#(
  parameter int CPU_ID = 0,
  parameter int CPU_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [CPU_W-1:0] bus_cpu,
  input  logic             tgt_bit,
  input  logic             sel_other,
  input  logic             sel_self,
  input  logic             hw_present,
  output logic             cand_valid,
  output logic [31:0]      cand_word
);
  // index 0 = "other", index 1 = "self"
  logic [1:0] pend_q, mask_q, pend_d, mask_d, live, sel;
  logic       me, show_self, deliver;

  assign me   = (bus_cpu == CPU_W'(CPU_ID));
  assign sel  = {sel_self, sel_other};
  assign live = pend_q & ~mask_q;

  assign show_self  = !live[0];
  assign cand_valid = |live;
  assign cand_word  = evt_word(TYPE_IPI, show_self ? NUM_SELF : NUM_OTHER);

  assign deliver = (op == OP_EVENT) && me && !hw_present && cand_valid;

  always_comb begin
    pend_d = pend_q;
    mask_d = mask_q;
    unique case (op)
      OP_SEND: begin
        if (tgt_bit) pend_d[0] = 1'b1;
        if (me && sel_self) pend_d[1] = 1'b1;
      end
      OP_ACK:  if (me) pend_d = pend_q & ~sel;
      OP_MSET: if (me) mask_d = mask_q | sel;
      OP_MCLR: if (me) mask_d = mask_q & ~sel;
      OP_EVENT: if (deliver) mask_d[show_self] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 2'b00;
      mask_q <= 2'b11;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/ipi_event_mux.sv
module ipi_event_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  op_e                       op,
  input  logic [CPU_W-1:0]          bus_cpu,
  input  logic [NUM_CPU-1:0]        hw_valid,
  input  logic [NUM_CPU*NUM_W-1:0]  hw_num,
  input  logic [NUM_CPU-1:0]        cand_valid,
  input  logic [NUM_CPU*32-1:0]     cand_word,
  output logic [31:0]               rdata_d
);
  logic cpu_ok;
  assign cpu_ok = (int'(bus_cpu) < NUM_CPU);

  always_comb begin
    rdata_d = 32'h0;
    if (op == OP_WHOAMI) begin
      rdata_d = 32'(bus_cpu);
    end else if (op == OP_EVENT && cpu_ok) begin
      if (hw_valid[bus_cpu])
        rdata_d = evt_word(TYPE_HW, hw_num[bus_cpu*NUM_W +: NUM_W]);
      else if (cand_valid[bus_cpu])
        rdata_d = cand_word[bus_cpu*32 +: 32];
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [CPU_W-1:0]           bus_cpu,
  input  logic [15:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NUM_CPU-1:0]         hw_valid,
  input  logic [NUM_CPU*NUM_W-1:0]   hw_num,
  output logic [NUM_CPU-1:0]         cand_valid,
  output logic [NUM_CPU*32-1:0]      cand_word
);
  op_e         op;
  logic [31:0] rdata_d;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata;

  ipi_decode u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .op        (op)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    ipi_cpu_slot #(.CPU_ID(c), .CPU_W(CPU_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .op         (op),
      .bus_cpu    (bus_cpu),
      .tgt_bit    (bus_wdata[c]),
      .sel_other  (bus_wdata[SEL_OTHER]),
      .sel_self   (bus_wdata[SEL_SELF]),
      .hw_present (hw_valid[c]),
      .cand_valid (cand_valid[c]),
      .cand_word  (cand_word[c*32 +: 32])
    );
  end

  ipi_event_mux #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_mux (
    .op         (op),
    .bus_cpu    (bus_cpu),
    .hw_valid   (hw_valid),
    .hw_num     (hw_num),
    .cand_valid (cand_valid),
    .cand_word  (cand_word),
    .rdata_d    (rdata_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 32'h0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= rdata_d;
      bus_rvalid <= bus_valid && !bus_write;
    end
  end
endmodule

// File: rtl/ipi_unit_checker.sv
module ipi_unit_checker #(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [CPU_W-1:0]      bus_cpu,
  input logic [15:0]           bus_addr,
  input logic [31:0]           bus_rdata,
  input logic                  bus_rvalid,
  input logic [NUM_CPU-1:0]    hw_valid,
  input logic [NUM_CPU-1:0]    cand_valid
);
  logic rd_req, ev_rd, who_rd;
  assign rd_req = bus_valid && !bus_write;
  assign ev_rd  = rd_req && bus_addr == 16'h2004;
  assign who_rd = rd_req && bus_addr == 16'h2000;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cand_valid == '0 && !bus_rvalid));

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  assert_no_spurious_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  assert_ipi_encoding_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_rd && !hw_valid[bus_cpu] && cand_valid[bus_cpu])
      |=> (bus_rdata[31:16] == 16'h0004 && bus_rdata[15:2] == '0));

  assert_hw_first_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_rd && hw_valid[bus_cpu]) |=> (bus_rdata[31:16] == 16'h0001));

  assert_whoami_R10: assert property (@(posedge clk) disable iff (rst)
    who_rd |=> (bus_rdata == 32'($past(bus_cpu))));
endmodule

bind ipi_unit ipi_unit_checker #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .hw_valid   (hw_valid),
  .cand_valid (cand_valid)
);

// File: tb/sim_ipi_unit.sv
`timescale 1ns/1ps
module sim_ipi_unit;
  localparam int NC = 4;
  localparam int CW = 2;

  logic            clk = 0;
  logic            rst = 1;
  logic            bus_valid = 0, bus_write = 0;
  logic [CW-1:0]   bus_cpu = '0;
  logic [15:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NC-1:0]   hw_valid = '0;
  logic [NC*16-1:0] hw_num = '0;
  logic [NC-1:0]   cand_valid;
  logic [NC*32-1:0] cand_word;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_unit #(.NUM_CPU(NC)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .hw_valid(hw_valid),
    .hw_num(hw_num), .cand_valid(cand_valid), .cand_word(cand_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_cpu = CW'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int cpu, input logic [15:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_cpu = CW'(cpu); bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  function automatic logic [31:0] word_of(int c);
    return cand_word[c*32 +: 32];
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset cand", 32'(cand_valid), 0);
    chk("R1 reset rvalid", 32'(bus_rvalid), 0);
    for (int c = 0; c < NC; c++) wr(c, 16'h2028, 32'h8000_0001);
    chk("R1 nothing pending after unmask", 32'(cand_valid), 0);

    for (int c = 0; c < NC; c++) begin
      rd(c, 16'h2000, d, v);
      chk("R10 whoami", d, c);
      chk("R11 rvalid after read", 32'(v), 1);
    end
    @(negedge clk);
    chk("R11 rvalid drops", 32'(bus_rvalid), 0);
    rd(0, 16'h2004, d, v);
    chk("R11 empty event", d, 0);

    // R2 sweep over all target patterns
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < NC; c++) wr(c, 16'h200C, 32'h8000_0001);
      wr(m % NC, 16'h2008, 32'(m));
      chk("R2 send targets", 32'(cand_valid), m);
      for (int c = 0; c < NC; c++)
        if (m[c]) chk("R4 other word", word_of(c), 32'h0004_0001);
    end

    // R3 self
    for (int c = 0; c < NC; c++) wr(c, 16'h200C, 32'h8000_0001);
    wr(2, 16'h2008, 32'h8000_0000);
    chk("R3 self on writer only", 32'(cand_valid), 32'b0100);
    chk("R4 self word", word_of(2), 32'h0004_0002);

    // R8 / R7
    wr(2, 16'h2008, 32'h0000_0004);
    chk("R8 other first cand", word_of(2), 32'h0004_0001);
    rd(2, 16'h2004, d, v);
    chk("R8 event other", d, 32'h0004_0001);
    chk("R7 other auto-masked", word_of(2), 32'h0004_0002);
    rd(2, 16'h2004, d, v);
    chk("R4 event self", d, 32'h0004_0002);
    chk("R7 both masked", 32'(cand_valid[2]), 0);
    rd(2, 16'h2004, d, v);
    chk("R11 event empty after delivery", d, 0);
    wr(2, 16'h2028, 32'h0000_0001);
    chk("R7 pending kept", word_of(2), 32'h0004_0001);

    // R5 ack
    wr(1, 16'h200C, 32'h8000_0001);
    chk("R5 other cpu ack no effect", 32'(cand_valid[2]), 1);
    wr(2, 16'h200C, 32'h0000_0001);
    chk("R5 ack other", 32'(cand_valid[2]), 0);
    wr(2, 16'h2028, 32'h8000_0000);
    chk("R5 self still pending", word_of(2), 32'h0004_0002);
    wr(2, 16'h200C, 32'h8000_0000);
    chk("R5 ack self", 32'(cand_valid[2]), 0);

    // R6 mask
    wr(0, 16'h2008, 32'h0000_0008);
    chk("R6 cpu3 pending", 32'(cand_valid[3]), 1);
    wr(0, 16'h2024, 32'h0000_0001);
    chk("R6 foreign mask no effect", 32'(cand_valid[3]), 1);
    wr(3, 16'h2024, 32'h7FFF_FFFE);
    chk("R6 middle bits no effect", 32'(cand_valid[3]), 1);
    wr(3, 16'h2024, 32'h0000_0001);
    chk("R6 mask set", 32'(cand_valid[3]), 0);
    wr(3, 16'h2028, 32'h8000_0000);
    chk("R6 bit31 leaves other", 32'(cand_valid[3]), 0);
    wr(3, 16'h2028, 32'h0000_0001);
    chk("R6 mask clear", 32'(cand_valid[3]), 1);

    // R9 hw priority
    @(negedge clk);
    hw_valid[3] = 1; hw_num[3*16 +: 16] = 16'h0123;
    rd(3, 16'h2004, d, v);
    chk("R9 hw word", d, 32'h0001_0123);
    chk("R9 ipi not masked", 32'(cand_valid[3]), 1);
    hw_valid[3] = 0;
    rd(3, 16'h2004, d, v);
    chk("R9 ipi after hw", d, 32'h0004_0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule